// File: doc/BRIEF.md
# Virtual Address Translation Fast Path

This block turns one virtual address per request into a physical address for a load, a store or an instruction fetch. Each request carries a 64-bit VA, an address space number, an access kind and a privilege bit. The block first checks that the VA is properly sign-extended. A kernel-segment address is then mapped straight to a physical address without the TLB. Every other address is looked up in a small fully associative TLB, and a hit is checked for page presence, privilege and fault-on conditions. The block answers with a 3-bit result code and, on success, the PA.

The TLB is written only through a fill port. Each write goes to the next slot in round-robin order. The block never walks page tables: a lookup that finds no matching entry comes back as a miss, and the requester decides what to do next. Requests use a valid/ready handshake, and each accepted request gets exactly one response on the following cycle.

Top module: `vx_xlate_fast`

## Requirements
- R1: `req_ready` is low exactly while `fill_valid` is high. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `rsp_valid` is high for one cycle, the cycle after the acceptance, and stays low otherwise.
- R2: If VA bits 63..42 are not all equal to bit 42, the code is NonCanonical (2). This applies in either mode and before any other check.
- R3: A canonical VA with bits [42:41] = 2'b10 in kernel mode (`req_user` = 0) gives Success (0) with no TLB lookup. Its PA is VA bits [40:0], zero-extended to 44 bits.
- R4: The same kernel-segment VA in user mode (`req_user` = 1) gives AccessViolation (7).
- R5: A TLB entry hits when its stored VPN equals VA[42:13] and its ASN equals `req_asn`. On a hit that passes every check, the PA is {PFN, VA[12:0]}.
- R6: When no entry matches (different VPN or different ASN), the code is TlbMiss (1). For every code other than Success, `rsp_pa` is zero.
- R7: A hit on an entry whose page-valid bit (`fill_pte_v`) is 0 gives PageNotPresent (3).
- R8: `fill_perm` = {user write, user read, kernel write, kernel read}. Access kinds are 0 = load, 1 = store, 2 = fetch. A load or fetch needs the read enable of the current mode, and a store needs its write enable. A failure gives AccessViolation (7).
- R9: `fill_fo` = {fault-on-execute, fault-on-write, fault-on-read}. After the permission check passes, a load with fault-on-read gives 4, a store with fault-on-write gives 5, and a fetch with fault-on-execute gives 6. A fault-on bit for a different access kind has no effect. When both the permission and a fault-on bit would fail, the code is 7.
- R10: Fills go to slots 0, 1, ... up to 15 and then wrap around. The 17th fill after reset replaces the first entry and leaves the other 15 in place.
- R11: After reset the TLB holds no entries, so every non-kernel-segment canonical lookup misses. `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 64 | Virtual address |
| req_asn | input | 8 | Address space number |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| fill_valid | input | 1 | Write one TLB entry |
| fill_vpn | input | 30 | Virtual page number of the entry |
| fill_asn | input | 8 | Address space number of the entry |
| fill_pfn | input | 31 | Physical frame number of the entry |
| fill_perm | input | 4 | {user write, user read, kernel write, kernel read} |
| fill_fo | input | 3 | {fault-on-execute, fault-on-write, fault-on-read} |
| fill_pte_v | input | 1 | Page-valid bit of the entry |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | Result code |
| rsp_pa | output | 44 | Physical address, zero unless Success |

## Verification
The bench builds the block with its default parameters: a 64-bit VA with 43 significant bits, 8 KB pages, a 44-bit PA, 8-bit ASNs and 16 TLB slots. A depth of 16 keeps the wrap of the round-robin pointer within 17 fills, so eviction of the oldest entry can be observed directly. The 43-bit VA width puts both the sign-extension boundary and the kernel-segment selector bits at fixed positions that the vectors target precisely. With a 13-bit page offset, a PA can be checked as a frame number concatenated with the offset bits.

// File: rtl/vx_pkg.sv
package vx_pkg;

   typedef enum logic [2:0] {
      VX_OK         = 3'd0,
      VX_MISS       = 3'd1,
      VX_NONCANON   = 3'd2,
      VX_NOTPRESENT = 3'd3,
      VX_FLT_RD     = 3'd4,
      VX_FLT_WR     = 3'd5,
      VX_FLT_EX     = 3'd6,
      VX_ACCV       = 3'd7
   } vx_code_e;

   typedef enum logic [1:0] {
      VX_LOAD  = 2'd0,
      VX_STORE = 2'd1,
      VX_FETCH = 2'd2
   } vx_acc_e;

   // Per-entry attribute bits kept alongside tag and frame
   typedef struct packed {
      logic pte_v;
      logic uwe;
      logic ure;
      logic kwe;
      logic kre;
      logic f_ex;
      logic f_wr;
      logic f_rd;
   } vx_attr_t;

endpackage

// File: rtl/vx_va_classify.sv
module vx_va_classify #(
   parameter int VA_W    = 64,
   parameter int VA_BITS = 43
) (
   input  logic [VA_W-1:0] va,
   output logic            canon,
   output logic            kseg
);
   // Top two significant bits select the kernel segment
   assign kseg = (va[VA_BITS-1:VA_BITS-2] == 2'b10);

   generate
      if (VA_W == VA_BITS) begin : g_full
         assign canon = 1'b1;
      end else begin : g_ext
         localparam int EXT_W = VA_W - VA_BITS + 1;
         logic [EXT_W-1:0] ext;
         assign ext   = va[VA_W-1:VA_BITS-1];
         assign canon = (&ext) | ~(|ext);
      end
   endgenerate
endmodule

// File: rtl/vx_tlb_cam.sv
module vx_tlb_cam
   import vx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int VPN_W = 30,
   parameter int PFN_W = 31,
   parameter int ASN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [ASN_W-1:0] fill_asn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  vx_attr_t         fill_attr,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [ASN_W-1:0] lk_asn,
   output logic             hit,
   output logic [PFN_W-1:0] hit_pfn,
   output vx_attr_t         hit_attr
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [IDX_W-1:0] victim;
   logic [DEPTH-1:0] used;
   logic [DEPTH-1:0] match;
   logic [VPN_W-1:0] vpn_q  [DEPTH];
   logic [ASN_W-1:0] asn_q  [DEPTH];
   logic [PFN_W-1:0] pfn_q  [DEPTH];
   vx_attr_t         attr_q [DEPTH];
   logic [IDX_W-1:0] sel;

   always_ff @(posedge clk) begin
      if (!rst_n)
         victim <= '0;
      else if (fill_en)
         victim <= (victim == IDX_W'(DEPTH-1)) ? '0 : victim + 1'b1;
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic wr;
      assign wr = fill_en && (victim == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n)
            used[e] <= 1'b0;
         else if (wr)
            used[e] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (wr) begin
            vpn_q[e]  <= fill_vpn;
            asn_q[e]  <= fill_asn;
            pfn_q[e]  <= fill_pfn;
            attr_q[e] <= fill_attr;
         end
      end

      assign match[e] = used[e] && (vpn_q[e] == lk_vpn) && (asn_q[e] == lk_asn);
   end

   // Lowest matching slot wins
   always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int e = DEPTH - 1; e >= 0; e--) begin
         if (match[e]) begin
            hit = 1'b1;
            sel = IDX_W'(e);
         end
      end
   end

   assign hit_pfn  = pfn_q[sel];
   assign hit_attr = attr_q[sel];
endmodule

// File: rtl/vx_access_check.sv
module vx_access_check
   import vx_pkg::*;
(
   input  logic [1:0] acc,
   input  logic       user,
   input  vx_attr_t   attr,
   output vx_code_e   code
);
   logic rd_ok, wr_ok, perm_ok;

   assign rd_ok   = user ? attr.ure : attr.kre;
   assign wr_ok   = user ? attr.uwe : attr.kwe;
   assign perm_ok = (acc == VX_STORE) ? wr_ok : rd_ok;

   always_comb begin
      if (!attr.pte_v)
         code = VX_NOTPRESENT;
      else if (!perm_ok)
         code = VX_ACCV;
      else if (acc == VX_LOAD && attr.f_rd)
         code = VX_FLT_RD;
      else if (acc == VX_STORE && attr.f_wr)
         code = VX_FLT_WR;
      else if (acc == VX_FETCH && attr.f_ex)
         code = VX_FLT_EX;
      else
         code = VX_OK;
   end
endmodule

// File: rtl/vx_xlate_fast.sv
module vx_xlate_fast
   import vx_pkg::*;
#(
   parameter int VA_W         = 64,
   parameter int VA_BITS      = 43,
   parameter int PAGE_SHIFT   = 13,
   parameter int PA_W         = 44,
   parameter int ASN_W        = 8,
   parameter int TLB_DEPTH    = 16,
   parameter int KSEG_PA_BITS = 41,
   localparam int VPN_W       = VA_BITS - PAGE_SHIFT,
   localparam int PFN_W       = PA_W - PAGE_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_va,
   input  logic [ASN_W-1:0] req_asn,
   input  logic [1:0]       req_acc,
   input  logic             req_user,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [ASN_W-1:0] fill_asn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic [3:0]       fill_perm,
   input  logic [2:0]       fill_fo,
   input  logic             fill_pte_v,
   output logic             rsp_valid,
   output logic [2:0]       rsp_code,
   output logic [PA_W-1:0]  rsp_pa
);
   if (VA_BITS > VA_W || VA_BITS < PAGE_SHIFT + 3) begin : g_bad_va
      $error("vx_xlate_fast: VA_BITS out of range");
   end
   if (PA_W <= PAGE_SHIFT || PA_W < KSEG_PA_BITS || KSEG_PA_BITS > VA_BITS - 2) begin : g_bad_pa
      $error("vx_xlate_fast: PA_W or KSEG_PA_BITS out of range");
   end
   if (TLB_DEPTH < 2) begin : g_bad_depth
      $error("vx_xlate_fast: TLB_DEPTH must be at least 2");
   end

   logic             canon, kseg, hit, accept;
   logic [PFN_W-1:0] hit_pfn;
   vx_attr_t         hit_attr, fill_attr;
   vx_code_e         chk_code, nxt_code;
   logic [PA_W-1:0]  nxt_pa;

   assign req_ready = !fill_valid;
   assign accept    = req_valid && req_ready;

   assign fill_attr = '{pte_v: fill_pte_v,
                        uwe: fill_perm[3], ure: fill_perm[2],
                        kwe: fill_perm[1], kre: fill_perm[0],
                        f_ex: fill_fo[2], f_wr: fill_fo[1], f_rd: fill_fo[0]};

   vx_va_classify #(.VA_W(VA_W), .VA_BITS(VA_BITS)) u_class (
      .va(req_va), .canon(canon), .kseg(kseg));

   vx_tlb_cam #(.DEPTH(TLB_DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASN_W(ASN_W)) u_cam (
      .clk(clk), .rst_n(rst_n),
      .fill_en(fill_valid), .fill_vpn(fill_vpn), .fill_asn(fill_asn),
      .fill_pfn(fill_pfn), .fill_attr(fill_attr),
      .lk_vpn(req_va[VA_BITS-1:PAGE_SHIFT]), .lk_asn(req_asn),
      .hit(hit), .hit_pfn(hit_pfn), .hit_attr(hit_attr));

   vx_access_check u_chk (
      .acc(req_acc), .user(req_user), .attr(hit_attr), .code(chk_code));

   // Fixed order: sign extension, kernel segment, then TLB
   always_comb begin
      nxt_pa = '0;
      if (!canon)
         nxt_code = VX_NONCANON;
      else if (kseg) begin
         nxt_code = req_user ? VX_ACCV : VX_OK;
         if (!req_user) nxt_pa = PA_W'(req_va[KSEG_PA_BITS-1:0]);
      end else if (!hit)
         nxt_code = VX_MISS;
      else begin
         nxt_code = chk_code;
         if (chk_code == VX_OK) nxt_pa = {hit_pfn, req_va[PAGE_SHIFT-1:0]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_code  <= 3'd0;
         rsp_pa    <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_code <= nxt_code;
            rsp_pa   <= nxt_pa;
         end
      end
   end
endmodule

// File: rtl/vx_xlate_chk.sv
module vx_xlate_chk #(
   parameter int VA_W         = 64,
   parameter int VA_BITS      = 43,
   parameter int PA_W         = 44,
   parameter int KSEG_PA_BITS = 41
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_va,
   input logic            req_user,
   input logic            fill_valid,
   input logic            rsp_valid,
   input logic [2:0]      rsp_code,
   input logic [PA_W-1:0] rsp_pa
);
   logic            acc_c, bad_ext, in_kseg;
   logic [PA_W-1:0] kpa;

   assign acc_c   = req_valid && req_ready;
   assign bad_ext = !((req_va[VA_W-1:VA_BITS-1] == '0) || (req_va[VA_W-1:VA_BITS-1] == '1));
   assign in_kseg = req_va[VA_BITS-1] && !req_va[VA_BITS-2];
   assign kpa     = PA_W'(req_va[KSEG_PA_BITS-1:0]);

   assert_fill_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> !req_ready);
   assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c |=> rsp_valid);
   assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_c |=> !rsp_valid);
   assert_noncanon_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_c && bad_ext) |=> (rsp_code == 3'd2));
   assert_kseg_kernel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_c && !bad_ext && in_kseg && !req_user) |=> (rsp_code == 3'd0 && rsp_pa == $past(kpa)));
   assert_kseg_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_c && !bad_ext && in_kseg && req_user) |=> (rsp_code == 3'd7));
   assert_pa_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != 3'd0) |-> (rsp_pa == '0));
endmodule

bind vx_xlate_fast vx_xlate_chk #(
   .VA_W(VA_W), .VA_BITS(VA_BITS), .PA_W(PA_W), .KSEG_PA_BITS(KSEG_PA_BITS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_va(req_va), .req_user(req_user), .fill_valid(fill_valid),
   .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pa(rsp_pa));

// File: tb/vx_xlate_fast_tb_top.sv
module vx_xlate_fast_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_va = '0;
   logic [7:0]  req_asn = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic        fill_valid = 1'b0;
   logic [29:0] fill_vpn = '0;
   logic [7:0]  fill_asn = '0;
   logic [30:0] fill_pfn = '0;
   logic [3:0]  fill_perm = '0;
   logic [2:0]  fill_fo = '0;
   logic        fill_pte_v = 1'b0;
   logic        rsp_valid;
   logic [2:0]  rsp_code;
   logic [43:0] rsp_pa;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   vx_xlate_fast dut_i (.*);

   typedef struct packed {
      logic [63:0] va;
      logic [7:0]  asn;
      logic [1:0]  acc;
      logic        user;
      logic [2:0]  code;
      logic [43:0] pa;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{64'h2123, 8'd5, 2'd0, 1'b0, 3'd0, 44'h200123, 8'd5},              // R5 kernel load hit
      '{64'h2123, 8'd5, 2'd1, 1'b1, 3'd0, 44'h200123, 8'd5},              // R5 user store hit
      '{64'h2123, 8'd6, 2'd0, 1'b0, 3'd1, 44'h0, 8'd6},                   // R6 asn mismatch
      '{64'h4000, 8'd5, 2'd0, 1'b1, 3'd7, 44'h0, 8'd8},                   // R8 user load, kernel-only page
      '{64'h4000, 8'd5, 2'd1, 1'b0, 3'd0, 44'h400000, 8'd8},              // R8 kernel store allowed
      '{64'h6008, 8'd5, 2'd0, 1'b0, 3'd4, 44'h0, 8'd9},                   // R9 fault-on-read
      '{64'h6008, 8'd5, 2'd1, 1'b0, 3'd0, 44'h600008, 8'd9},              // R9 store ignores FOR
      '{64'h8000, 8'd5, 2'd1, 1'b0, 3'd5, 44'h0, 8'd9},                   // R9 fault-on-write
      '{64'hA000, 8'd5, 2'd2, 1'b0, 3'd6, 44'h0, 8'd9},                   // R9 fault-on-execute
      '{64'hA000, 8'd5, 2'd0, 1'b0, 3'd0, 44'hA00000, 8'd9},              // R9 load ignores FOE
      '{64'hC000, 8'd5, 2'd0, 1'b0, 3'd3, 44'h0, 8'd7},                   // R7 page not present
      '{64'hE000, 8'd5, 2'd1, 1'b0, 3'd7, 44'h0, 8'd9},                   // R9 perm before FOW
      '{64'hFFFF_FC00_1234_5678, 8'd5, 2'd0, 1'b0, 3'd0, 44'h000_1234_5678, 8'd3}, // R3
      '{64'hFFFF_FC00_1234_5678, 8'd5, 2'd0, 1'b1, 3'd7, 44'h0, 8'd4},    // R4
      '{64'h0000_0800_0000_0000, 8'd5, 2'd0, 1'b0, 3'd2, 44'h0, 8'd2},    // R2
      '{64'h7FFF_FC00_0000_0000, 8'd5, 2'd0, 1'b1, 3'd2, 44'h0, 8'd2},    // R2 beats kseg
      '{64'hFFFF_FE00_0000_2123, 8'd5, 2'd0, 1'b0, 3'd1, 44'h0, 8'd6},    // R6 other VPN
      '{64'h4000, 8'd5, 2'd2, 1'b1, 3'd7, 44'h0, 8'd8},                   // R8 user fetch needs ure
      '{64'hE000, 8'd5, 2'd0, 1'b0, 3'd0, 44'hE00000, 8'd9}               // R9 load ignores FOW
   };

   task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic fill(input logic [29:0] vpn, input logic [7:0] asn, input logic [30:0] pfn,
                       input logic [3:0] perm, input logic [2:0] fo, input logic v);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = vpn; fill_asn = asn; fill_pfn = pfn;
      fill_perm = perm; fill_fo = fo; fill_pte_v = v;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   // Issues one request; returns after the response cycle's negedge
   task automatic issue(input logic [63:0] va, input logic [7:0] asn, input logic [1:0] acc,
                        input logic user);
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_asn = asn; req_acc = acc; req_user = user;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R11: reset state
      @(negedge clk);
      check(rsp_valid == 1'b0, "R11 rsp_valid", 64'(rsp_valid), 0);
      check(req_ready == 1'b1, "R11 req_ready", 64'(req_ready), 1);
      issue(64'h2123, 8'd5, 2'd0, 1'b0);
      check(rsp_code == 3'd1, "R11 empty TLB miss", 64'(rsp_code), 1);

      fill(30'd1, 8'd5, 31'h100, 4'b1111, 3'b000, 1'b1);
      fill(30'd2, 8'd5, 31'h200, 4'b0011, 3'b000, 1'b1);
      fill(30'd3, 8'd5, 31'h300, 4'b1111, 3'b001, 1'b1);
      fill(30'd4, 8'd5, 31'h400, 4'b1111, 3'b010, 1'b1);
      fill(30'd5, 8'd5, 31'h500, 4'b1111, 3'b100, 1'b1);
      fill(30'd6, 8'd5, 31'h600, 4'b1111, 3'b000, 1'b0);
      fill(30'd7, 8'd5, 31'h700, 4'b0001, 3'b010, 1'b1);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i].va, VEC[i].asn, VEC[i].acc, VEC[i].user);
         check(rsp_valid && rsp_code == VEC[i].code, $sformatf("R%0d code vec%0d", VEC[i].rq, i),
               64'(rsp_code), 64'(VEC[i].code));
         check(rsp_pa == VEC[i].pa, $sformatf("R%0d pa vec%0d", VEC[i].rq, i),
               64'(rsp_pa), 64'(VEC[i].pa));
      end

      // R1: response lasts one cycle
      issue(64'h2123, 8'd5, 2'd0, 1'b0);
      check(rsp_valid == 1'b1, "R1 rsp one cycle later", 64'(rsp_valid), 1);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1 rsp drops", 64'(rsp_valid), 0);

      // R1: a fill blocks acceptance of a waiting request
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = 30'd8; fill_asn = 8'd5; fill_pfn = 31'h800;
      fill_perm = 4'b1111; fill_fo = 3'b000; fill_pte_v = 1'b1;
      req_valid = 1'b1; req_va = 64'h10000; req_asn = 8'd5; req_acc = 2'd0; req_user = 1'b0;
      #1;
      check(req_ready == 1'b0, "R1 ready low in fill", 64'(req_ready), 0);
      @(negedge clk);
      fill_valid = 1'b0;
      check(rsp_valid == 1'b0, "R1 not accepted during fill", 64'(rsp_valid), 0);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid && rsp_code == 3'd0 && rsp_pa == 44'h1000000, "R1 accepted after fill",
            64'(rsp_pa), 64'h1000000);

      // R10: round-robin wrap evicts the first entry
      do_reset();
      for (int k = 0; k < 17; k++)
         fill(30'(100 + k), 8'd9, 31'(k + 1), 4'b1111, 3'b000, 1'b1);
      issue({34'd0, 30'd100, 13'd0} >> 0, 8'd9, 2'd0, 1'b0);
      check(rsp_code == 3'd1, "R10 oldest evicted", 64'(rsp_code), 1);
      issue(64'({30'd101, 13'h5}), 8'd9, 2'd0, 1'b0);
      check(rsp_code == 3'd0 && rsp_pa == 44'h4005, "R10 second kept", 64'(rsp_pa), 64'h4005);
      issue(64'({30'd116, 13'h0}), 8'd9, 2'd0, 1'b0);
      check(rsp_code == 3'd0 && rsp_pa == 44'h22000, "R10 newest in slot 0", 64'(rsp_pa), 64'h22000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule